// File: doc/BRIEF.md
# PLL Settle Guard and System Clock Switch

This block stands between the clock configuration written by software and the system clock of the chip. It keeps the crystal-select code and the PLL power-down bit that drive the PLL. It also keeps the request to run the chip from the PLL. A relock starts in two cases: the crystal code is written with a value that differs from the stored one, or the PLL leaves power-down. Either case loads a down counter that runs on the oscillator clock. While that counter is nonzero, the chip stays on the oscillator, even if software asked for the PLL in the same write. When the count runs out, the clock selection follows the stored request on its own, and a lock flag is raised.

Software can poll the raw lock flag or enable an interrupt from it through a mask input. It clears the flag with a one-cycle clear strobe. The final clock is made by a handover multiplexer. The multiplexer turns off the old source on that source's falling edge before it turns on the new one, so the output never carries a shortened pulse.

Top module: `pll_relock_ctrl`

## Requirements
- R1: After reset, pll_pwrdn is 1, pll_xtal equals the XTAL_RST parameter, and sel_pll, lock_raw and lock_irq are 0. sys_clk is driven from clk_osc.
- R2: A write whose crystal code differs from pll_xtal, made while the PLL is in Normal mode, starts a relock: lock_raw drops and sel_pll is 0 two cycles after the write. A write with the same code does not disturb a completed lock.
- R3: When a relock starts on clock edge t, lock_raw is 0 through edge t+RELOAD-1 and becomes 1 at edge t+RELOAD.
- R4: sel_pll stays 0 for the whole settle period, including when the relock-starting write also sets the use-PLL request.
- R5: sel_pll is 1 exactly one cycle after the lock completes when use-PLL is stored, with no further write. sel_pll returns to 0 one cycle after use-PLL is written to 0 (two edges after the write).
- R6: A write with cfg_pwrdn=1 sets pll_pwrdn, clears lock_raw on the next edge and brings sel_pll to 0. The following power-up waits the full RELOAD count.
- R7: A relock trigger that arrives while a count is running restarts the full RELOAD count from that write.
- R8: lock_irq is registered and equals the next lock_raw value ANDed with lock_mask. lock_clr=1 clears lock_raw on the next edge, but a lock completing on that same edge wins and lock_raw becomes 1.
- R9: The oscillator and PLL paths are never enabled together. No sys_clk phase is shorter than the shorter half period of the two clocks. Once sel_pll has been stable, sys_clk follows clk_pll when sel_pll=1 and follows clk_osc when sel_pll=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator reference; clocks all control logic |
| clk_pll | input | 1 | PLL output clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe, one clk_osc cycle |
| cfg_xtal | input | XTAL_W | Crystal-select code to store |
| cfg_pwrdn | input | 1 | 1 puts the PLL in power-down, 0 selects Normal mode |
| cfg_use_pll | input | 1 | Request to run the system clock from the PLL |
| lock_clr | input | 1 | Write-one-to-clear strobe for lock_raw |
| lock_mask | input | 1 | Enables lock_irq from lock_raw |
| pll_pwrdn | output | 1 | Stored power-down bit driving the PLL |
| pll_xtal | output | XTAL_W | Stored crystal code driving the PLL translation |
| sel_pll | output | 1 | System clock source request after the settle guard (1 = PLL) |
| lock_raw | output | 1 | Raw lock status |
| lock_irq | output | 1 | Masked lock interrupt |
| sys_clk | output | 1 | Glitch-free system clock |

## Verification
The assertions assume that cfg_we, lock_clr and lock_mask change only between rising edges of clk_osc. They also assume that rst is held for several cycles of both clocks, and that clk_pll keeps toggling during a handover even after power-down is requested. The stimulus drives every input on the falling edge of clk_osc and keeps both clocks free-running for the whole run. It uses two unrelated periods, so handovers fall at many different phase offsets. The short RELOAD used on the bench keeps every settle window, retrigger and power cycle inside the run. The clear strobe is placed on the very edge where the count expires.

// File: rtl/prl_pkg.sv
`timescale 1ns/1ps
package prl_pkg;
  // command issued to the settle timer each oscillator cycle
  typedef enum logic [1:0] {
    TMR_HOLD = 2'd0,  // keep counting down (or idle at zero)
    TMR_LOAD = 2'd1,  // start a full settle period
    TMR_STOP = 2'd2   // abandon the count (power-down)
  } tmr_cmd_e;
endpackage

// File: rtl/prl_settle_timer.sv
`timescale 1ns/1ps
module prl_settle_timer #(
  parameter int unsigned RELOAD = 32'h1200
) (
  input  logic               clk,
  input  logic               rst,
  input  prl_pkg::tmr_cmd_e  cmd,
  output logic               busy,
  output logic               expire
);
  localparam int CNT_W = $clog2(RELOAD + 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(RELOAD);
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      case (cmd)
        prl_pkg::TMR_LOAD: cnt <= LOAD_V;
        prl_pkg::TMR_STOP: cnt <= '0;
        default:           if (cnt != '0) cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign busy   = (cnt != '0);
  assign expire = (cmd == prl_pkg::TMR_HOLD) && (cnt == LAST_V);

  // R7: any trigger restarts the full count
  a_r7_reload_on_trigger: assert property (@(posedge clk) disable iff (rst)
    (cmd == prl_pkg::TMR_LOAD) |=> (cnt == LOAD_V));
  // R3: the count never exceeds the reload value
  a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LOAD_V);
  // R3: an undisturbed count steps down by one
  a_r3_steps_down: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd == prl_pkg::TMR_HOLD) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/prl_lock_status.sv
`timescale 1ns/1ps
module prl_lock_status (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic drop,
  input  logic clr,
  input  logic mask,
  output logic locked,
  output logic raw,
  output logic irq
);
  logic raw_nxt;

  always_comb begin
    if (set_evt)          raw_nxt = 1'b1;
    else if (drop || clr) raw_nxt = 1'b0;
    else                  raw_nxt = raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      raw    <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (drop)         locked <= 1'b0;
      else if (set_evt) locked <= 1'b1;
      raw <= raw_nxt;
      irq <= raw_nxt & mask;
    end
  end

  // R8: a completing lock beats a clear on the same edge
  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> raw);
  // R8: the interrupt is never raised without the raw flag
  a_r8_irq_needs_raw: assert property (@(posedge clk) disable iff (rst)
    irq |-> raw);
  // R6: a restart or power-down drops the lock
  a_r6_drop_unlocks: assert property (@(posedge clk) disable iff (rst)
    drop |=> (!locked && !raw));
endmodule

// File: rtl/prl_clk_mux.sv
`timescale 1ns/1ps
module prl_clk_mux (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst,
  input  logic sel_b,
  output logic clk_out
);
  logic arm_a, arm_b;
  logic en_a, en_b;

  // each side arms only when the other side is fully idle
  always_ff @(posedge clk_a) begin
    if (rst) arm_a <= 1'b1;
    else     arm_a <= !sel_b && !en_b && !arm_b;
  end

  always_ff @(negedge clk_a) begin
    if (rst) en_a <= 1'b1;
    else     en_a <= arm_a;
  end

  always_ff @(posedge clk_b) begin
    if (rst) arm_b <= 1'b0;
    else     arm_b <= sel_b && !en_a && !arm_a;
  end

  always_ff @(negedge clk_b) begin
    if (rst) en_b <= 1'b0;
    else     en_b <= arm_b;
  end

  assign clk_out = (clk_a & en_a) | (clk_b & en_b);

  // R9: the two paths are never open together
  a_r9_paths_exclusive: assert property (@(posedge clk_a) disable iff (rst)
    !(en_a && en_b));
endmodule

// File: rtl/pll_relock_ctrl.sv
`timescale 1ns/1ps
module pll_relock_ctrl #(
  parameter int unsigned XTAL_W   = 5,
  parameter int unsigned XTAL_RST = 0,
  parameter int unsigned RELOAD   = 32'h1200
) (
  input  logic              clk_osc,
  input  logic              clk_pll,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [XTAL_W-1:0] cfg_xtal,
  input  logic              cfg_pwrdn,
  input  logic              cfg_use_pll,
  input  logic              lock_clr,
  input  logic              lock_mask,
  output logic              pll_pwrdn,
  output logic [XTAL_W-1:0] pll_xtal,
  output logic              sel_pll,
  output logic              lock_raw,
  output logic              lock_irq,
  output logic              sys_clk
);
  localparam logic [XTAL_W-1:0] XTAL_INIT = XTAL_W'(XTAL_RST);

  logic              use_q;
  logic              relock_go, pwr_off;
  logic              busy, expire, locked;
  prl_pkg::tmr_cmd_e tmr_cmd;

  // relock on a real code change in Normal mode, or on leaving power-down
  assign relock_go = cfg_we && !cfg_pwrdn && (pll_pwrdn || (cfg_xtal != pll_xtal));
  assign pwr_off   = cfg_we && cfg_pwrdn;

  always_comb begin
    if (relock_go)    tmr_cmd = prl_pkg::TMR_LOAD;
    else if (pwr_off) tmr_cmd = prl_pkg::TMR_STOP;
    else              tmr_cmd = prl_pkg::TMR_HOLD;
  end

  always_ff @(posedge clk_osc) begin
    if (rst) begin
      pll_xtal  <= XTAL_INIT;
      pll_pwrdn <= 1'b1;
      use_q     <= 1'b0;
      sel_pll   <= 1'b0;
    end else begin
      if (cfg_we) begin
        pll_xtal  <= cfg_xtal;
        pll_pwrdn <= cfg_pwrdn;
        use_q     <= cfg_use_pll;
      end
      sel_pll <= use_q && locked;
    end
  end

  prl_settle_timer #(.RELOAD(RELOAD)) u_timer (
    .clk    (clk_osc),
    .rst    (rst),
    .cmd    (tmr_cmd),
    .busy   (busy),
    .expire (expire)
  );

  prl_lock_status u_status (
    .clk     (clk_osc),
    .rst     (rst),
    .set_evt (expire),
    .drop    (relock_go || pwr_off),
    .clr     (lock_clr),
    .mask    (lock_mask),
    .locked  (locked),
    .raw     (lock_raw),
    .irq     (lock_irq)
  );

  prl_clk_mux u_mux (
    .clk_a   (clk_osc),
    .clk_b   (clk_pll),
    .rst     (rst),
    .sel_b   (sel_pll),
    .clk_out (sys_clk)
  );

  // R4: while settling, the next selection is the oscillator
  a_r4_hold_on_osc: assert property (@(posedge clk_osc) disable iff (rst)
    busy |=> !sel_pll);
  // R5: the PLL is selected only after a completed lock
  a_r5_sel_after_lock: assert property (@(posedge clk_osc) disable iff (rst)
    $rose(sel_pll) |-> $past(locked));
  // R2: rewriting the same code in Normal mode starts no count
  a_r2_same_code_quiet: assert property (@(posedge clk_osc) disable iff (rst)
    (cfg_we && !cfg_pwrdn && !pll_pwrdn && cfg_xtal == pll_xtal && !busy) |=> !busy);
  // R6: power-down drops the lock at once
  a_r6_pwrdn_drops_lock: assert property (@(posedge clk_osc) disable iff (rst)
    pwr_off |=> (pll_pwrdn && !lock_raw));
  // R6: power-down returns the selection to the oscillator
  a_r6_pwrdn_to_osc: assert property (@(posedge clk_osc) disable iff (rst)
    pwr_off |=> ##1 !sel_pll);
endmodule

// File: tb/pll_relock_ctrl_bench.sv
`timescale 1ns/1ps
module pll_relock_ctrl_bench;
  localparam int XW  = 5;
  localparam int RLD = 20;

  logic clk_osc = 1'b0;
  logic clk_pll = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [XW-1:0] cfg_xtal = '0;
  logic cfg_pwrdn = 1'b1;
  logic cfg_use_pll = 1'b0;
  logic lock_clr = 1'b0;
  logic lock_mask = 1'b0;
  logic pll_pwrdn, sel_pll, lock_raw, lock_irq, sys_clk;
  logic [XW-1:0] pll_xtal;

  always #2 clk_osc = ~clk_osc;        // 250 MHz
  always #1.55 clk_pll = ~clk_pll;     // unrelated PLL clock

  pll_relock_ctrl #(.XTAL_W(XW), .XTAL_RST(0), .RELOAD(RLD)) u_pll_relock_ctrl (
    .clk_osc(clk_osc), .clk_pll(clk_pll), .rst(rst),
    .cfg_we(cfg_we), .cfg_xtal(cfg_xtal), .cfg_pwrdn(cfg_pwrdn),
    .cfg_use_pll(cfg_use_pll), .lock_clr(lock_clr), .lock_mask(lock_mask),
    .pll_pwrdn(pll_pwrdn), .pll_xtal(pll_xtal), .sel_pll(sel_pll),
    .lock_raw(lock_raw), .lock_irq(lock_irq), .sys_clk(sys_clk)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int      m_cnt = 0;
  bit      m_ok = 0, m_raw = 0, m_irq = 0, m_sel = 0, m_pd = 1, m_use = 0;
  int      m_xtal = 0;
  bit      cmp_on = 0;

  always @(posedge clk_osc) begin
    bit go, off, lock;
    if (rst) begin
      m_cnt = 0; m_ok = 0; m_raw = 0; m_irq = 0; m_sel = 0;
      m_pd = 1; m_use = 0; m_xtal = 0;
    end else begin
      go   = cfg_we && !cfg_pwrdn && (m_pd || int'(cfg_xtal) != m_xtal);
      off  = cfg_we && cfg_pwrdn;
      lock = !go && !off && (m_cnt == 1);
      m_sel = m_use && m_ok;
      if (go) m_cnt = RLD;
      else if (off) m_cnt = 0;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (go || off) m_ok = 0;
      else if (lock) m_ok = 1;
      if (lock) m_raw = 1;
      else if (go || off || lock_clr) m_raw = 0;
      m_irq = m_raw && lock_mask;
      if (cfg_we) begin
        m_xtal = int'(cfg_xtal); m_pd = cfg_pwrdn; m_use = cfg_use_pll;
      end
    end
  end

  always @(negedge clk_osc) begin
    if (cmp_on) begin
      chk("R2", "model pll_xtal", pll_xtal, m_xtal);
      chk("R6", "model pll_pwrdn", pll_pwrdn, m_pd);
      chk("R5", "model sel_pll", sel_pll, m_sel);
      chk("R3", "model lock_raw", lock_raw, m_raw);
      chk("R8", "model lock_irq", lock_irq, m_irq);
    end
  end

  // ---------------- R9 pulse-width monitor ----------------
  bit      mon_on = 0;
  realtime last_edge = 0.0;
  int      short_cnt = 0;
  always @(sys_clk) begin
    if (mon_on) begin
      if ($realtime - last_edge < 1.54) short_cnt++;
    end
    last_edge = $realtime;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk_osc);
  endtask

  task automatic wr(input int x, input bit pd, input bit use_p);
    @(negedge clk_osc);
    cfg_we = 1'b1; cfg_xtal = XW'(x); cfg_pwrdn = pd; cfg_use_pll = use_p;
    @(negedge clk_osc);
    cfg_we = 1'b0;
  endtask

  task automatic follow_pll(input string tag);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk_pll); #0.5;
      chk(tag, "sys_clk high with PLL", sys_clk, 1);
      @(negedge clk_pll); #0.5;
      chk(tag, "sys_clk low with PLL", sys_clk, 0);
    end
  endtask

  task automatic follow_osc(input string tag);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk_osc); #0.5;
      chk(tag, "sys_clk high with osc", sys_clk, 1);
      @(negedge clk_osc); #0.5;
      chk(tag, "sys_clk low with osc", sys_clk, 0);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #800000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit sel_seen;
    step(8);
    rst = 1'b0;
    step(1);
    // R1: reset state
    chk("R1", "pll_pwrdn", pll_pwrdn, 1);
    chk("R1", "pll_xtal", pll_xtal, 0);
    chk("R1", "sel_pll", sel_pll, 0);
    chk("R1", "lock_raw", lock_raw, 0);
    chk("R1", "lock_irq", lock_irq, 0);
    follow_osc("R1");
    step(1);
    cmp_on = 1; mon_on = 1;

    // power up and request PLL in one write; clear collides with lock
    lock_mask = 1'b1;
    wr(3, 0, 1);
    sel_seen = 0;
    for (int k = 1; k < RLD; k++) begin
      step(1);
      sel_seen |= sel_pll;
    end
    chk("R3", "raw before expiry", lock_raw, 0);
    lock_clr = 1'b1;
    step(1);
    lock_clr = 1'b0;
    chk("R8", "lock beats same-edge clear", lock_raw, 1);
    chk("R8", "irq with mask set", lock_irq, 1);
    chk("R4", "sel held low during settle", sel_seen | sel_pll, 0);
    step(1);
    chk("R5", "auto switch after lock", sel_pll, 1);
    step(10);
    follow_pll("R9");
    step(1);

    // same code again: no disturbance
    wr(3, 0, 1);
    step(3);
    chk("R2", "same code keeps raw", lock_raw, 1);
    chk("R2", "same code keeps sel", sel_pll, 1);

    // W1C clear, then mask off
    lock_clr = 1'b1; step(1); lock_clr = 1'b0;
    chk("R8", "clear drops raw", lock_raw, 0);
    chk("R8", "clear drops irq", lock_irq, 0);
    lock_mask = 1'b0;

    // code change starts relock, then retrigger mid-count
    wr(5, 0, 1);
    step(1);
    chk("R2", "code change drops sel", sel_pll, 0);
    step(7);
    wr(6, 0, 1);
    step(RLD - 1);
    chk("R7", "retrigger raw still low", lock_raw, 0);
    step(1);
    chk("R7", "retrigger full count", lock_raw, 1);
    chk("R8", "irq masked off", lock_irq, 0);
    step(2);
    chk("R5", "sel after relock", sel_pll, 1);

    // power-down then power-up
    wr(6, 1, 1);
    chk("R6", "pwrdn clears raw", lock_raw, 0);
    step(1);
    chk("R6", "pwrdn forces osc", sel_pll, 0);
    step(10);
    follow_osc("R9");
    step(4);
    wr(6, 0, 1);
    step(RLD - 1);
    chk("R6", "power-up raw still low", lock_raw, 0);
    step(1);
    chk("R6", "power-up full count", lock_raw, 1);
    step(2);
    chk("R5", "sel after power-up", sel_pll, 1);

    // withdraw the request
    wr(6, 0, 0);
    step(1);
    chk("R5", "sel drops with request", sel_pll, 0);
    chk("R2", "request-only write keeps raw", lock_raw, 1);
    step(10);
    follow_osc("R9");

    chk("R9", "short sys_clk phases", short_cnt, 0);
    finish_run();
  end
endmodule